// File: doc/BRIEF.md
# Page recall sequencer

The page recall sequencer restores a set of stored channel settings into an output register file. Non-volatile storage holds four pages, and each page has twelve 8-bit words. A full recall reads one page word by word and writes each word into the matching channel register. Channel 1 is written first and channel 12 last, one channel per clock cycle. The block drives the read port of a synchronous memory array and produces one-hot write strobes plus a data bus for the register file.

A full recall can start in three ways. The first is automatically, once, after reset, from the page on the page-select pins. The second is a rising edge on the recall pin, again from the page-select pins. The third is a recall-all command from the command decoder, from the page the command carries. The decoder can also ask for a single channel to be recalled.

The page is captured when a recall starts, so the select pins may change while the recall runs. Recalls started by the pin or by power-up also emit a one-cycle pulse that clears the programming-enable latch of the storage. A busy output covers the whole operation. For a short interval after each recall, further pin edges are rejected.

Top module: `page_recall_seq`

## Requirements
- R1: After reset is released, and with no other stimulus, the block performs one full recall of the page given by `page_sel`.
- R2: A rising edge on `recall_pin`, seen while the block is idle and not in hold-off, starts a full recall of the page on `page_sel`. That page is captured at the start, so changing `page_sel` during the recall has no effect on it.
- R3: A full recall writes the channels in ascending order, channel 1 first and channel 12 last, one per cycle. Bit k of `ch_wr_en` is channel k+1. The read address is page*12 + (channel-1). Read data is returned one cycle after `mem_rd_en`, and each write strobe comes one cycle after its read.
- R4: `busy` goes high in the cycle after the trigger is sampled and falls in the cycle after the last write strobe. This gives 13 busy cycles for a full recall and 2 for a single-channel recall. After reset, `busy`, `mem_rd_en` and `ch_wr_en` are all low.
- R5: `wen_clr` pulses for exactly one cycle, together with the first busy cycle, on every recall started by power-up or by `recall_pin`. It stays low for command-started recalls.
- R6: `recall_pin` edges, `cmd_all` and `cmd_one` that arrive while `busy` is high are ignored.
- R7: A `recall_pin` edge that comes within `HOLDOFF_CYC` cycles after any recall ends is ignored. An edge that comes later is accepted.
- R8: A `cmd_all` pulse seen while the block is idle performs a full recall of page `cmd_page`.
- R9: A `cmd_one` pulse seen while the block is idle reads only word `cmd_page`*12 + `cmd_ch` and writes only channel `cmd_ch`+1. A `cmd_ch` value of 12 or more is ignored.
- R10: When triggers arrive in the same cycle, the power-up recall wins over a `recall_pin` edge, which wins over `cmd_all`, which wins over `cmd_one`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_pin | input | 1 | External recall request, edge detected |
| page_sel | input | 2 | Page selected by the address pins |
| cmd_all | input | 1 | Decoder request: recall every channel |
| cmd_one | input | 1 | Decoder request: recall one channel |
| cmd_page | input | 2 | Page for decoder requests |
| cmd_ch | input | 4 | Channel index (0..11) for a single recall |
| busy | output | 1 | Recall in progress |
| wen_clr | output | 1 | One-cycle pulse that clears the programming-enable latch |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 6 | Memory word address |
| mem_rd_data | input | 8 | Memory read data, one cycle after the strobe |
| ch_wr_en | output | 12 | One-hot channel register write strobes |
| ch_wr_data | output | 8 | Channel register write data |

## Verification
The hardest situations to reach from the ports involve timing against the hold-off window and against a running recall. The bench fires a pin edge on the very first idle cycle after a recall, which must be rejected. It then fires another edge just past the window, which must be accepted. In the middle of a recall, it raises the pin and `cmd_all` and also moves `page_sel`. The outcome must still be exactly twelve writes from the page captured at the start. Random recalls then follow, over randomly rewritten memory contents, and a bench-side model of the register file is compared against the design after every one.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FULL = 2'd1,
    ST_ONE  = 2'd2
  } prs_state_e;

endpackage

// File: rtl/prs_trigger.sv
module prs_trigger #(
  parameter int NUM_CH      = 12,
  parameter int PAGE_W      = 2,
  parameter int CH_W        = 4,
  parameter int HOLDOFF_CYC = 8,
  localparam int HOLD_W     = $clog2(HOLDOFF_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recall_pin,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              cmd_all,
  input  logic              cmd_one,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [CH_W-1:0]   cmd_ch,
  input  logic              idle,
  input  logic              done,
  output logic              start,
  output logic              start_full,
  output logic [PAGE_W-1:0] start_page,
  output logic [CH_W-1:0]   start_ch,
  output logic              start_clr
);

  logic              pin_prev_q, pin_prev_d;
  logic              por_q, por_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              pin_rise;
  logic              hold_act;
  logic              ch_ok;

  assign pin_rise = recall_pin & ~pin_prev_q;
  assign hold_act = (hold_q != '0);
  assign ch_ok    = (int'(cmd_ch) < NUM_CH);

  // arbitration: power-up, pin, recall-all, single channel
  always_comb begin
    start      = 1'b0;
    start_full = 1'b1;
    start_page = page_sel;
    start_ch   = '0;
    start_clr  = 1'b0;
    if (idle) begin
      if (por_q) begin
        start     = 1'b1;
        start_clr = 1'b1;
      end else if (pin_rise && !hold_act) begin
        start     = 1'b1;
        start_clr = 1'b1;
      end else if (cmd_all) begin
        start      = 1'b1;
        start_page = cmd_page;
      end else if (cmd_one && ch_ok) begin
        start      = 1'b1;
        start_full = 1'b0;
        start_page = cmd_page;
        start_ch   = cmd_ch;
      end
    end
  end

  always_comb begin
    pin_prev_d = recall_pin;
    por_d      = por_q & ~start;
    hold_d     = hold_q;
    if (done) begin
      hold_d = HOLD_W'(HOLDOFF_CYC);
    end else if (hold_act) begin
      hold_d = hold_q - HOLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev_q <= 1'b1;
      por_q      <= 1'b1;
      hold_q     <= '0;
    end else begin
      pin_prev_q <= pin_prev_d;
      por_q      <= por_d;
      hold_q     <= hold_d;
    end
  end

endmodule

// File: rtl/prs_fsm.sv
module prs_fsm
  import prs_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int PAGE_W = 2,
  parameter int CH_W   = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_full,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [CH_W-1:0]   start_ch,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CH_W-1:0]   rd_ch,
  output logic              rd_last,
  output logic              running
);

  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  prs_state_e        st_q, st_d;
  logic [CH_W-1:0]   idx_q, idx_d;
  logic [PAGE_W-1:0] page_q;
  logic              idx_en;
  logic              page_en;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    page_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = start_full ? ST_FULL : ST_ONE;
          idx_d   = start_full ? '0 : start_ch;
          idx_en  = 1'b1;
          page_en = 1'b1;
        end
      end
      ST_FULL: begin
        if (idx_q == LAST_CH) begin
          st_d = ST_IDLE;
        end else begin
          idx_d  = idx_q + CH_W'(1);
          idx_en = 1'b1;
        end
      end
      ST_ONE: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (page_en) begin
      page_q <= start_page;
    end
  end

  assign running = (st_q != ST_IDLE);
  assign rd_en   = running;
  assign rd_ch   = idx_q;
  assign rd_last = (st_q == ST_ONE) || (idx_q == LAST_CH);
  assign rd_addr = ADDR_W'(page_q) * ADDR_W'(NUM_CH) + ADDR_W'(idx_q);

endmodule

// File: rtl/prs_wrstage.sv
module prs_wrstage #(
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic              rd_last,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_pend,
  output logic [NUM_CH-1:0] wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);

  logic            v_q;
  logic [CH_W-1:0] ch_q;
  logic            last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= rd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      last_q <= 1'b0;
    end else if (rd_en) begin
      ch_q   <= rd_ch;
      last_q <= rd_last;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
    assign wr_en[g] = v_q && (ch_q == CH_W'(g));
  end

  assign wr_pend = v_q;
  assign wr_data = rd_data;
  assign done    = v_q & last_q;

endmodule

// File: rtl/page_recall_seq.sv
module page_recall_seq #(
  parameter int NUM_CH      = 12,
  parameter int DATA_W      = 8,
  parameter int NUM_PAGES   = 4,
  parameter int HOLDOFF_CYC = 8,
  localparam int PAGE_W     = $clog2(NUM_PAGES),
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int ADDR_W     = $clog2(NUM_PAGES * NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recall_pin,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              cmd_all,
  input  logic              cmd_one,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic [CH_W-1:0]   cmd_ch,
  output logic              busy,
  output logic              wen_clr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic [NUM_CH-1:0] ch_wr_en,
  output logic [DATA_W-1:0] ch_wr_data
);

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              start;
  logic              start_full;
  logic [PAGE_W-1:0] start_page;
  logic [CH_W-1:0]   start_ch;
  logic              start_clr;
  logic [CH_W-1:0]   rd_ch;
  logic              rd_last;
  logic              running;
  logic              wr_pend;
  logic              done;
  logic              wen_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[1];

  prs_trigger #(
    .NUM_CH     (NUM_CH),
    .PAGE_W     (PAGE_W),
    .CH_W       (CH_W),
    .HOLDOFF_CYC(HOLDOFF_CYC)
  ) u_trig (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .recall_pin(recall_pin),
    .page_sel  (page_sel),
    .cmd_all   (cmd_all),
    .cmd_one   (cmd_one),
    .cmd_page  (cmd_page),
    .cmd_ch    (cmd_ch),
    .idle      (~busy),
    .done      (done),
    .start     (start),
    .start_full(start_full),
    .start_page(start_page),
    .start_ch  (start_ch),
    .start_clr (start_clr)
  );

  prs_fsm #(
    .NUM_CH(NUM_CH),
    .PAGE_W(PAGE_W),
    .CH_W  (CH_W),
    .ADDR_W(ADDR_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (start),
    .start_full(start_full),
    .start_page(start_page),
    .start_ch  (start_ch),
    .rd_en     (mem_rd_en),
    .rd_addr   (mem_rd_addr),
    .rd_ch     (rd_ch),
    .rd_last   (rd_last),
    .running   (running)
  );

  prs_wrstage #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W),
    .DATA_W(DATA_W)
  ) u_wr (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .rd_en  (mem_rd_en),
    .rd_ch  (rd_ch),
    .rd_last(rd_last),
    .rd_data(mem_rd_data),
    .wr_pend(wr_pend),
    .wr_en  (ch_wr_en),
    .wr_data(ch_wr_data),
    .done   (done)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wen_q <= 1'b0;
    end else begin
      wen_q <= start & start_clr;
    end
  end

  assign wen_clr = wen_q;
  assign busy    = running | wr_pend;

endmodule

// File: rtl/prs_chk.sv
module prs_chk #(
  parameter int NUM_CH    = 12,
  parameter int NUM_PAGES = 4,
  parameter int ADDR_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wen_clr,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic [NUM_CH-1:0] ch_wr_en
);

  // R3
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr_en));

  // R3
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(1)));

  // R9
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (int'(mem_rd_addr) < NUM_PAGES * NUM_CH));

  // R4
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || (ch_wr_en != '0)) |-> busy);

  // R4
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wr_en[NUM_CH-1] |=> !busy);

  // R5
  wen_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wen_clr |-> $rose(busy));

  // R5
  wen_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wen_clr |=> !wen_clr);

endmodule

bind page_recall_seq prs_chk #(
  .NUM_CH   (NUM_CH),
  .NUM_PAGES(NUM_PAGES),
  .ADDR_W   (ADDR_W)
) u_prs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .wen_clr    (wen_clr),
  .mem_rd_en  (mem_rd_en),
  .mem_rd_addr(mem_rd_addr),
  .ch_wr_en   (ch_wr_en)
);

// File: tb/tb_page_recall_seq.sv
module tb_page_recall_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 12;
  localparam int NPG  = 4;
  localparam int HOLD = 8;

  logic        clk;
  logic        rst_n;
  logic        recall_pin;
  logic [1:0]  page_sel;
  logic        cmd_all;
  logic        cmd_one;
  logic [1:0]  cmd_page;
  logic [3:0]  cmd_ch;
  logic        busy;
  logic        wen_clr;
  logic        mem_rd_en;
  logic [5:0]  mem_rd_addr;
  logic [7:0]  mem_rd_data;
  logic [11:0] ch_wr_en;
  logic [7:0]  ch_wr_data;

  logic [7:0] mem [NPG*NCH];
  logic [7:0] rf [NCH];
  logic [7:0] exp_rf [NCH];

  int checks = 0;
  int failures = 0;
  int busy_cnt = 0;
  int wen_cnt = 0;
  int wr_cnt = 0;
  int wr_log [16];

  page_recall_seq #(.HOLDOFF_CYC(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .recall_pin(recall_pin), .page_sel(page_sel),
    .cmd_all(cmd_all), .cmd_one(cmd_one), .cmd_page(cmd_page), .cmd_ch(cmd_ch),
    .busy(busy), .wen_clr(wen_clr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .ch_wr_en(ch_wr_en), .ch_wr_data(ch_wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural memory, one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
  end

  // register file model
  always @(posedge clk) begin
    for (int k = 0; k < NCH; k++) begin
      if (ch_wr_en[k]) rf[k] <= ch_wr_data;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (wen_clr) wen_cnt++;
    for (int k = 0; k < NCH; k++) begin
      if (ch_wr_en[k]) begin
        if (wr_cnt < 16) wr_log[wr_cnt] = k;
        wr_cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_mon();
    busy_cnt = 0;
    wen_cnt  = 0;
    wr_cnt   = 0;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    @(negedge clk);
    while (busy && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    #1;
    check(guard < 200, "R4 busy never fell", guard, 0);
  endtask

  task automatic exp_full(input int p);
    for (int k = 0; k < NCH; k++) exp_rf[k] = mem[p*NCH + k];
  endtask

  function automatic int rf_miss();
    int m;
    m = 0;
    for (int k = 0; k < NCH; k++) if (rf[k] !== exp_rf[k]) m++;
    return m;
  endfunction

  function automatic int order_miss();
    int m;
    m = 0;
    for (int k = 0; k < NCH; k++) if (wr_log[k] != k) m++;
    return m;
  endfunction

  task automatic pulse_pin();
    recall_pin = 1'b1;
    @(negedge clk);
    recall_pin = 1'b0;
  endtask

  task automatic pulse_all(input logic [1:0] p);
    cmd_all = 1'b1; cmd_page = p;
    @(negedge clk);
    cmd_all = 1'b0;
  endtask

  task automatic pulse_one(input logic [1:0] p, input logic [3:0] c);
    cmd_one = 1'b1; cmd_page = p; cmd_ch = c;
    @(negedge clk);
    cmd_one = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p;
    int c;
    int op;
    void'($urandom(32'd4711));
    rst_n = 1'b0; recall_pin = 1'b0; page_sel = 2'd2;
    cmd_all = 1'b0; cmd_one = 1'b0; cmd_page = 2'd0; cmd_ch = 4'd0;
    for (int i = 0; i < NPG*NCH; i++) mem[i] = 8'($urandom);
    for (int k = 0; k < NCH; k++) rf[k] = 8'hxx;
    tick(3);
    check(busy == 1'b0 && ch_wr_en == '0 && mem_rd_en == 1'b0, "R4 reset state",
          int'(busy), 0);

    // R1: power-up recall
    clr_mon();
    rst_n = 1'b1;
    tick(5);
    check(busy == 1'b1, "R1 power-up recall started", int'(busy), 1);
    wait_idle();
    exp_full(2);
    check(rf_miss() == 0, "R1 power-up page contents", rf_miss(), 0);
    check(order_miss() == 0, "R3 power-up order", order_miss(), 0);
    check(wen_cnt == 1, "R5 power-up wen_clr pulse", wen_cnt, 1);

    // R2/R3/R4: pin recall
    tick(HOLD + 2);
    page_sel = 2'd1;
    clr_mon();
    pulse_pin();
    wait_idle();
    exp_full(1);
    check(rf_miss() == 0, "R2 pin recall contents", rf_miss(), 0);
    check(busy_cnt == 13, "R4 full recall busy length", busy_cnt, 13);
    check(wr_cnt == 12, "R3 full recall write count", wr_cnt, 12);
    check(order_miss() == 0, "R3 pin recall order", order_miss(), 0);
    check(wen_cnt == 1, "R5 pin wen_clr pulse", wen_cnt, 1);

    // R7: hold-off
    clr_mon();
    page_sel = 2'd3;
    pulse_pin();
    tick(3);
    check(busy_cnt == 0 && wr_cnt == 0, "R7 edge in hold-off ignored", busy_cnt, 0);
    tick(HOLD);
    clr_mon();
    pulse_pin();
    wait_idle();
    exp_full(3);
    check(rf_miss() == 0 && wr_cnt == 12, "R7 edge after hold-off accepted", wr_cnt, 12);

    // R6/R2: triggers during busy ignored, page latched
    tick(HOLD + 2);
    page_sel = 2'd0;
    clr_mon();
    pulse_pin();
    tick(3);
    page_sel = 2'd2;
    cmd_all = 1'b1; cmd_page = 2'd3; recall_pin = 1'b1;
    tick(1);
    cmd_all = 1'b0; recall_pin = 1'b0;
    wait_idle();
    exp_full(0);
    check(rf_miss() == 0, "R2 page latched at start", rf_miss(), 0);
    check(wr_cnt == 12 && busy_cnt == 13, "R6 triggers during busy ignored", wr_cnt, 12);

    // R8: recall-all command
    tick(HOLD + 2);
    for (int k = 0; k < NCH; k++) mem[2*NCH + k] = 8'(k * 17 + 3);
    clr_mon();
    pulse_all(2'd2);
    wait_idle();
    exp_full(2);
    check(rf_miss() == 0, "R8 recall-all contents", rf_miss(), 0);
    check(wen_cnt == 0, "R5 no wen_clr for command", wen_cnt, 0);
    check(order_miss() == 0, "R3 recall-all order", order_miss(), 0);

    // R9: single channel, including last channel
    tick(2);
    mem[1*NCH + 11] = 8'hA5;
    clr_mon();
    pulse_one(2'd1, 4'd11);
    wait_idle();
    exp_rf[11] = 8'hA5;
    check(rf_miss() == 0, "R9 single channel only", rf_miss(), 0);
    check(busy_cnt == 2 && wr_cnt == 1, "R4 single busy length", busy_cnt, 2);
    clr_mon();
    pulse_one(2'd0, 4'd12);
    tick(3);
    check(busy_cnt == 0 && wr_cnt == 0, "R9 out-of-range channel ignored", wr_cnt, 0);

    // R10: priority pin over command
    tick(HOLD + 2);
    page_sel = 2'd3;
    clr_mon();
    recall_pin = 1'b1; cmd_all = 1'b1; cmd_page = 2'd1;
    cmd_one = 1'b1; cmd_ch = 4'd0;
    tick(1);
    recall_pin = 1'b0; cmd_all = 1'b0; cmd_one = 1'b0;
    wait_idle();
    exp_full(3);
    check(rf_miss() == 0 && wen_cnt == 1, "R10 pin wins over commands", rf_miss(), 0);
    clr_mon();
    cmd_all = 1'b1; cmd_page = 2'd0; cmd_one = 1'b1; cmd_ch = 4'd2;
    tick(1);
    cmd_all = 1'b0; cmd_one = 1'b0;
    wait_idle();
    exp_full(0);
    check(rf_miss() == 0 && wr_cnt == 12, "R10 recall-all wins over single", wr_cnt, 12);

    // random mix
    for (int it = 0; it < 24; it++) begin
      for (int j = 0; j < 4; j++) mem[$urandom_range(0, NPG*NCH-1)] = 8'($urandom);
      op = $urandom_range(0, 2);
      p  = $urandom_range(0, NPG-1);
      c  = $urandom_range(0, NCH-1);
      tick(HOLD + 2);
      clr_mon();
      case (op)
        0: begin page_sel = 2'(p); pulse_pin(); exp_full(p); end
        1: begin pulse_all(2'(p)); exp_full(p); end
        default: begin pulse_one(2'(p), 4'(c)); exp_rf[c] = mem[p*NCH + c]; end
      endcase
      wait_idle();
      check(rf_miss() == 0, "R8 R9 R2 random recall contents", rf_miss(), 0);
      if (op != 2) check(order_miss() == 0, "R3 random order", order_miss(), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule